// File: doc/BRIEF.md
# Synchronizable Phase-Accumulator NCO

This block produces the phase word for a quadrature downconverter's sine/cosine lookup. A 32-bit accumulator adds a programmable tuning word on each cycle in which it is allowed to advance. The phase output is the accumulator plus a programmable phase offset. The accumulator normally advances every clock. When fractional-rate timing is selected, it advances only in the cycles where a separate advance-enable input is high.

Several oscillators can be kept phase-aligned. In master mode the block emits a one-cycle sync pulse while the accumulator, with a programmable mask applied, reads zero. This gives a window around the phase zero crossing. In slave mode an incoming sync pulse clears the masked accumulator bits, which aligns those most significant bits to the master. In master mode, any write or read of the tuning word restarts the phase from zero. In slave mode, retuning keeps the phase continuous. Software reaches four registers through a one-cycle write/read port.

Top module: `phase_nco_sync`

## Requirements
- R1: After reset the tuning word and the phase offset read 0, the sync mask reads 0xFFFFFFFF, the mode register reads 0 (master), the accumulator is 0 and sync_out is 0.
- R2: In each advancing cycle that has no clear, the accumulator grows by the tuning word, modulo 2^32. phase_out always equals the accumulator plus the phase offset, modulo 2^32.
- R3: With frac_mode = 1 the accumulator advances only on clock edges where adv_en is 1, once for each such edge, and holds otherwise. With frac_mode = 0 it advances on every edge.
- R4: In master mode, sync_out is 1 in the cycle after a cycle in which (accumulator AND mask) == 0, and 0 otherwise. In slave mode sync_out stays 0.
- R5: In slave mode, sync_in = 1 at a clock edge sets the accumulator to (accumulator AND NOT mask). This replaces the advance for that edge.
- R6: In master mode, sync_in has no effect on the accumulator.
- R7: In master mode, a write or a read of the tuning register (address 0) clears the accumulator to 0 at that edge. The clear takes precedence over any advance.
- R8: In slave mode, a write of the tuning register does not clear the accumulator. The old tuning word still applies at the write edge, and the new one applies from the next edge.
- R9: Register map: address 0 holds the tuning word, 1 the phase offset, 2 the sync mask and 3 the mode (bit 0 = 1 selects slave; the other bits read 0). cfg_rdata shows the addressed register combinationally, and a write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (matters for the tuning register) |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed register |
| frac_mode | input | 1 | 1 = advance gated by adv_en |
| adv_en | input | 1 | Advance enable for fractional-rate timing |
| sync_in | input | 1 | External sync pulse (slave mode) |
| phase_out | output | 32 | Accumulator plus phase offset |
| sync_out | output | 1 | Master sync pulse |

## Verification
Two of the block's functions can act on the accumulator at the same clock edge: the free-running advance and a clear, either a slave sync or a master retune. The bench holds the advance on, in the plain rate mode, while it pulses sync_in in slave mode and while it accesses the tuning register in master mode. It expects exactly the masked or full clear and no added tuning word. It also retunes in slave mode and checks that the phase continues through the write, with one step at the old rate followed by steps at the new rate.

// File: rtl/nco_pkg.sv
package nco_pkg;
    typedef enum logic [1:0] {
        REG_TUNE = 2'd0,
        REG_OFFS = 2'd1,
        REG_MASK = 2'd2,
        REG_MODE = 2'd3
    } nco_reg_e;
endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs
    import nco_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  tune,
    output logic [W-1:0]  offs,
    output logic [W-1:0]  mask,
    output logic          slave
);
    typedef struct packed {
        logic [W-1:0] tune;
        logic [W-1:0] offs;
        logic [W-1:0] mask;
        logic         slave;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (nco_reg_e'(addr))
                REG_TUNE: cfg_d.tune  = wdata;
                REG_OFFS: cfg_d.offs  = wdata;
                REG_MASK: cfg_d.mask  = wdata;
                REG_MODE: cfg_d.slave = wdata[0];
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.tune  <= '0;
            cfg_q.offs  <= '0;
            cfg_q.mask  <= '1;
            cfg_q.slave <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        case (nco_reg_e'(addr))
            REG_TUNE: rdata = cfg_q.tune;
            REG_OFFS: rdata = cfg_q.offs;
            REG_MASK: rdata = cfg_q.mask;
            REG_MODE: rdata = {{(W-1){1'b0}}, cfg_q.slave};
            default:  rdata = '0;
        endcase
    end

    assign tune  = cfg_q.tune;
    assign offs  = cfg_q.offs;
    assign mask  = cfg_q.mask;
    assign slave = cfg_q.slave;

    // R9: a mode write lands at the next edge
    p_mode_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(REG_MODE)) |=> (slave == $past(wdata[0])));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tune,
    input  logic [W-1:0] mask,
    input  logic         slave,
    input  logic         adv,
    input  logic         force_clr,
    input  logic         slave_sync,
    output logic [W-1:0] acc,
    output logic         sync_out
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         sync;
    } acc_t;

    acc_t st_d, st_q;
    logic zero_hit;

    assign zero_hit = ((st_q.acc & mask) == '0);

    always_comb begin
        st_d = st_q;
        if (force_clr) begin
            st_d.acc = '0;
        end else if (slave_sync) begin
            st_d.acc = st_q.acc & ~mask;
        end else if (adv) begin
            st_d.acc = st_q.acc + tune;
        end
        st_d.sync = !slave && zero_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc      = st_q.acc;
    assign sync_out = st_q.sync;

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !force_clr && !slave_sync) |=> (acc == $past(acc) + $past(tune)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !force_clr && !slave_sync) |=> $stable(acc));

    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave && ((acc & mask) == '0)) |=> sync_out);

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slave |=> !sync_out);

    p_slave_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_sync && !force_clr) |=> ((acc & $past(mask)) == '0));

    p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (acc == '0));
endmodule

// File: rtl/phase_nco_sync.sv
module phase_nco_sync
    import nco_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_re,
    input  logic [AW-1:0] cfg_addr,
    input  logic [W-1:0]  cfg_wdata,
    output logic [W-1:0]  cfg_rdata,
    input  logic          frac_mode,
    input  logic          adv_en,
    input  logic          sync_in,
    output logic [W-1:0]  phase_out,
    output logic          sync_out
);
    logic [W-1:0] tune, offs, mask, acc;
    logic         slave, adv, force_clr, slave_sync, tune_hit;

    nco_cfg_regs #(.W(W), .AW(AW)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .tune  (tune),
        .offs  (offs),
        .mask  (mask),
        .slave (slave)
    );

    assign tune_hit   = (cfg_we || cfg_re) && (cfg_addr == AW'(REG_TUNE));
    assign force_clr  = !slave && tune_hit;
    assign slave_sync = slave && sync_in;
    assign adv        = !frac_mode || adv_en;

    nco_phase_acc #(.W(W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune       (tune),
        .mask       (mask),
        .slave      (slave),
        .adv        (adv),
        .force_clr  (force_clr),
        .slave_sync (slave_sync),
        .acc        (acc),
        .sync_out   (sync_out)
    );

    assign phase_out = acc + offs;

    // R6: master ignores sync_in
    p_master_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave && sync_in && !tune_hit && adv) |=> (acc == $past(acc) + $past(tune)));

    // R8: slave retune keeps phase continuous
    p_slave_tune_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slave && cfg_we && cfg_addr == AW'(REG_TUNE) && !sync_in && adv)
            |=> (acc == $past(acc) + $past(tune)));
endmodule

// File: tb/phase_nco_sync_tb.sv
module phase_nco_sync_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_re = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frac_mode = 1'b0, adv_en = 1'b0, sync_in = 1'b0;
    logic [31:0] phase_out;
    logic        sync_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    phase_nco_sync u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .frac_mode(frac_mode), .adv_en(adv_en), .sync_in(sync_in),
        .phase_out(phase_out), .sync_out(sync_out)
    );

    typedef struct packed {
        logic [31:0] tune;
        logic [31:0] offs;
        logic [31:0] n;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'h0000_0001, 32'h0000_0000, 32'd10},
        '{32'h1234_5678, 32'h0000_1000, 32'd7},
        '{32'h8000_0000, 32'h0000_0000, 32'd3},
        '{32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd5},
        '{32'h0ABC_DEF1, 32'hF000_0000, 32'd20}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_re = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_re = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, p, offs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 phase", phase_out, 32'h0);
        chk("R1 sync_out", {31'b0, sync_out}, 32'h0);
        rd(2'd2, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R1 mode", v, 32'h0);
        rd(2'd1, v); chk("R1 offset", v, 32'h0);
        rd(2'd0, v); chk("R1 tune", v, 32'h0);

        // R2/R7/R9 vector table: offset write, tune write (master clears), free run
        foreach (VEC[i]) begin
            wr(2'd1, VEC[i].offs);
            wr(2'd0, VEC[i].tune);
            chk("R7 clear after tune write", phase_out, VEC[i].offs);
            repeat (VEC[i].n) @(negedge clk);
            chk("R2 phase after run", phase_out, VEC[i].tune * VEC[i].n + VEC[i].offs);
            rd(2'd1, v); chk("R9 offset readback", v, VEC[i].offs);
        end

        // R7 read of tune register in master clears accumulator
        offs = VEC[4].offs;
        rd(2'd0, v);
        chk("R9 tune readback", v, VEC[4].tune);
        chk("R7 clear on read", phase_out, offs);

        // R3 fractional-rate gating
        wr(2'd1, 32'h0); offs = 32'h0;
        wr(2'd0, 32'h0000_0100);
        frac_mode = 1'b1; adv_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 hold while adv_en low", phase_out, 32'h0);
        adv_en = 1'b1;
        repeat (2) @(negedge clk);
        adv_en = 1'b0;
        @(negedge clk);
        chk("R3 two gated advances", phase_out, 32'h0000_0200);
        frac_mode = 1'b0;

        // R4 master sync window
        wr(2'd2, 32'hF000_0000);
        wr(2'd0, 32'h1000_0000);
        @(negedge clk);
        chk("R4 pulse after zero", {31'b0, sync_out}, 32'h1);
        @(negedge clk);
        chk("R4 no pulse outside window", {31'b0, sync_out}, 32'h0);
        repeat (15) @(negedge clk);
        chk("R4 pulse after wrap", {31'b0, sync_out}, 32'h1);

        // R6 master ignores sync_in (advance on, same edge)
        p = phase_out;
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R6 sync_in ignored in master", phase_out, p + 32'h1000_0000);

        // R5/R8 slave mode
        wr(2'd0, 32'h0123_4567);
        wr(2'd3, 32'h0000_0001);
        rd(2'd3, v); chk("R9 mode readback", v, 32'h1);
        repeat (5) @(negedge clk);
        p = phase_out;
        wr(2'd0, 32'h0000_0010);
        chk("R8 old tune at write edge", phase_out, p + 32'h0123_4567);
        @(negedge clk);
        chk("R8 new tune after write", phase_out, p + 32'h0123_4567 + 32'h10);
        p = phase_out;
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R5 masked clear beats advance", phase_out, p & 32'h0FFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        chk("R5 full clear", phase_out, 32'h0);
        @(negedge clk);
        chk("R4 slave never pulses", {31'b0, sync_out}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule